// File: doc/BRIEF.md
# TDM Frame Pulse Detector and Serial Timing Unit

This unit times one TDM serial port. It watches the interface clock and the 8 kHz frame synchronisation line. From the level the sync line rests at, it works out which of two backplane formats is present. With a positive pulse (the line rests low), bit boundaries fall on rising clock edges. With a negative pulse (the line rests high), they fall on falling clock edges. Once the format is settled, the unit runs bit and channel counters for the output frame and for the input frame. It issues a one-cycle transmit strobe for the parallel-to-serial converter and a one-cycle sample strobe for the serial-to-parallel converter, each carrying the bit and channel they belong to.

All logic runs on a fast core clock `clk`. The interface clock `sclk` and the sync line `fsync` are sampled together on that clock, so every interface clock edge becomes a single-cycle event. Two clock modes exist. In the double-rate mode the interface clock runs at twice the bit rate and a frame holds 32 channels. In the equal-rate modes the clock equals the bit rate and a frame holds 64 or 128 channels. In the equal-rate modes a programmable input offset can delay the input frame by up to four clock periods against the output frame, to absorb backplane skew.

The detector is a three-state machine. In HUNT it collects a first one-frame window of sync samples; the window end takes it to CONFIRM and records the resting-level vote. In CONFIRM it collects a second window. If the new vote agrees with the recorded one, it moves to LOCKED and latches the format. If the vote disagrees, it stays in CONFIRM and records the new vote. LOCKED is held until reset.

Top module: `tdm_frame_timer`

## Requirements
- R1: After reset `locked`, `fmt_neg`, `tx_stb`, `rx_stb` and `frame_stb` are all 0.
- R2: The format is chosen by majority. Over a window of one frame length (counted in rising `sclk` edges), `fsync` is sampled at every rising edge. A majority of high samples gives `fmt_neg`=1 (negative pulse, falling-edge boundaries). Otherwise `fmt_neg`=0 (positive pulse, rising-edge boundaries).
- R3: `locked` rises only at the end of a second window whose vote agrees with the first. It never rises within the first two windows after reset. Once high, `locked` and `fmt_neg` stay unchanged until reset.
- R4: A frame start is the first boundary edge at which `fsync` is sampled at its active level after being inactive at the previous boundary edge. There `frame_stb` and `tx_stb` pulse together with `tx_bit`=0 and `tx_ch`=0.
- R5: Boundary edges are rising edges when `fmt_neg`=0 and falling edges when `fmt_neg`=1. `tx_stb` only follows boundary edges, and `rx_stb` only follows the opposite edges.
- R6: With `rate_sel`=0 (double-rate clock, 32 channels), a bit cell spans two clock periods. `tx_stb` follows every second boundary edge from the frame start. `rx_stb` follows the opposite edge of the cell's second clock period, which is the three-quarter point of the cell.
- R7: With `rate_sel`=1 (64 channels) or 2 (128 channels), each clock period is one bit. `tx_stb` follows every boundary edge and `rx_stb` follows every opposite edge. Code 3 behaves as 2.
- R8: Bits count 0 to 7 within a channel. After bit 7 the channel number increments, and it wraps to 0 after the last channel of the frame.
- R9: In the equal-rate modes the input frame starts `in_ofs` clock periods after the output frame start, with `in_ofs` clamped to 4. The output counters are unaffected.
- R10: With `rate_sel`=0, `in_ofs` is ignored: the input frame coincides with the output frame.
- R11: Each strobe lasts one `clk` cycle. `tx_stb` and `rx_stb` never assert in the same cycle, and no strobe asserts while `locked` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, much faster than `sclk` |
| rst_n | input | 1 | Active-low synchronous reset |
| sclk | input | 1 | Interface clock level, sampled on `clk` |
| fsync | input | 1 | 8 kHz frame synchronisation line |
| rate_sel | input | 2 | 0: double-rate, 32 ch; 1: equal-rate, 64 ch; 2 or 3: equal-rate, 128 ch |
| in_ofs | input | 3 | Input frame delay in clock periods (clamped to 4, equal-rate only) |
| locked | output | 1 | Format has been detected and latched |
| fmt_neg | output | 1 | 1: negative pulse, falling-edge boundaries; 0: positive pulse |
| tx_stb | output | 1 | Transmit strobe at an output bit boundary |
| tx_bit | output | 3 | Output bit index for `tx_stb` |
| tx_ch | output | 7 | Output channel for `tx_stb` |
| frame_stb | output | 1 | Output frame start |
| rx_stb | output | 1 | Input sample strobe |
| rx_bit | output | 3 | Input bit index for `rx_stb` |
| rx_ch | output | 7 | Input channel for `rx_stb` |

## Verification
The hardest situation to reach is a locked unit whose input frame runs skewed against its output frame. That state exists only after two full frames of a consistent resting level and a valid pulse, and the bench cannot read the skew directly. The stimulus therefore comes from a bench model of the backplane. It drives the clock and sync line half-edge by half-edge in the chosen format, for several frames per case, with an offset that differs per case (one value above the clamp). From its own edge position it predicts the bit and channel every sample strobe must carry, including the samples at the start of a frame that still belong to the previous input frame.

// File: rtl/tfs_pkg.sv
package tfs_pkg;

    typedef enum logic [1:0] {
        ST_HUNT    = 2'd0,
        ST_CONFIRM = 2'd1,
        ST_LOCKED  = 2'd2
    } det_state_e;

    localparam logic [1:0] RATE_DOUBLE = 2'd0;
    localparam logic [1:0] RATE_EQ_MID = 2'd1;
    localparam int         MAX_IN_OFS  = 4;
    localparam int         BITS_PER_CH = 8;

endpackage

// File: rtl/tfs_edge_sync.sv
module tfs_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic fsync,
    output logic rise_ev,
    output logic fall_ev,
    output logic fp_lvl
);
    logic sclk_q1, sclk_q2, fp_q1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q1 <= 1'b0;
            sclk_q2 <= 1'b0;
            fp_q1   <= 1'b0;
        end else begin
            sclk_q1 <= sclk;
            sclk_q2 <= sclk_q1;
            fp_q1   <= fsync;
        end
    end

    // The sync level travels with the first clock stage, so each edge
    // event sees the sync value present when the edge arrived.
    assign rise_ev = sclk_q1 & ~sclk_q2;
    assign fall_ev = ~sclk_q1 & sclk_q2;
    assign fp_lvl  = fp_q1;

endmodule

// File: rtl/tfs_pol_detect.sv
module tfs_pol_detect
    import tfs_pkg::*;
#(
    parameter int WINW = 11
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rise_ev,
    input  logic            fp_lvl,
    input  logic [WINW-1:0] win_len,
    output logic            locked,
    output logic            pol_neg
);
    det_state_e      st, st_nx;
    logic [WINW-1:0] wcnt, hcnt;
    logic            vote, vote_nx, pol_r, pol_nx;
    logic            win_end, rest_hi;
    logic [WINW:0]   hi_total;

    assign win_end  = rise_ev && (wcnt == win_len - WINW'(1));
    assign hi_total = {1'b0, hcnt} + {{WINW{1'b0}}, fp_lvl};
    assign rest_hi  = hi_total > {1'b0, (win_len >> 1)};

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_HUNT;
        else        st <= st_nx;
    end

    // window sampling and latched decisions
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wcnt  <= '0;
            hcnt  <= '0;
            vote  <= 1'b0;
            pol_r <= 1'b0;
        end else begin
            vote  <= vote_nx;
            pol_r <= pol_nx;
            if (rise_ev && st != ST_LOCKED) begin
                if (win_end) begin
                    wcnt <= '0;
                    hcnt <= '0;
                end else begin
                    wcnt <= wcnt + WINW'(1);
                    hcnt <= hi_total[WINW-1:0];
                end
            end
        end
    end

    // next state and outputs
    always_comb begin
        st_nx   = st;
        vote_nx = vote;
        pol_nx  = pol_r;
        unique case (st)
            ST_HUNT: begin
                if (win_end) begin
                    vote_nx = rest_hi;
                    st_nx   = ST_CONFIRM;
                end
            end
            ST_CONFIRM: begin
                if (win_end) begin
                    if (rest_hi == vote) begin
                        pol_nx = rest_hi;
                        st_nx  = ST_LOCKED;
                    end else begin
                        vote_nx = rest_hi;
                    end
                end
            end
            ST_LOCKED: st_nx = ST_LOCKED;
            default:   st_nx = ST_HUNT;
        endcase
    end

    assign locked  = (st == ST_LOCKED);
    assign pol_neg = pol_r;

endmodule

// File: rtl/tfs_slot_counter.sv
module tfs_slot_counter #(
    parameter int CHW = 7
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           adv,
    input  logic           restart,
    input  logic           dbl,
    input  logic [CHW-1:0] ch_last,
    output logic           ph,
    output logic [2:0]     bit_idx,
    output logic [CHW-1:0] ch_idx,
    output logic           bnd_stb
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph      <= 1'b0;
            bit_idx <= '0;
            ch_idx  <= '0;
            bnd_stb <= 1'b0;
        end else begin
            bnd_stb <= 1'b0;
            if (adv) begin
                if (restart) begin
                    ph      <= 1'b0;
                    bit_idx <= '0;
                    ch_idx  <= '0;
                    bnd_stb <= 1'b1;
                end else if (dbl && !ph) begin
                    ph <= 1'b1;
                end else begin
                    ph      <= 1'b0;
                    bnd_stb <= 1'b1;
                    if (bit_idx == 3'd7) begin
                        bit_idx <= '0;
                        ch_idx  <= (ch_idx == ch_last) ? '0 : ch_idx + CHW'(1);
                    end else begin
                        bit_idx <= bit_idx + 3'd1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/tdm_frame_timer.sv
module tdm_frame_timer
    import tfs_pkg::*;
#(
    parameter  int BASE_CH = 32,
    localparam int CHW     = $clog2(BASE_CH * 4),
    localparam int WINW    = $clog2(BASE_CH * 4 * BITS_PER_CH) + 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sclk,
    input  logic           fsync,
    input  logic [1:0]     rate_sel,
    input  logic [2:0]     in_ofs,
    output logic           locked,
    output logic           fmt_neg,
    output logic           tx_stb,
    output logic [2:0]     tx_bit,
    output logic [CHW-1:0] tx_ch,
    output logic           frame_stb,
    output logic           rx_stb,
    output logic [2:0]     rx_bit,
    output logic [CHW-1:0] rx_ch
);
    logic            rise_ev, fall_ev, fp_lvl;
    logic            dbl, a_ev, b_ev, a_adv, fp_act, fp_prev;
    logic            tx_start, in_restart, rx_ph, tx_ph;
    logic [1:0]      rshift;
    logic [2:0]      ofs_eff, dly;
    logic [CHW-1:0]  ch_last;
    logic [WINW-1:0] win_len;

    assign dbl     = (rate_sel == RATE_DOUBLE);
    assign rshift  = dbl ? 2'd0 : (rate_sel == RATE_EQ_MID) ? 2'd1 : 2'd2;
    assign ch_last = CHW'((BASE_CH << rshift) - 1);
    assign win_len = WINW'((BASE_CH * BITS_PER_CH) << (int'(rshift) + int'(dbl)));
    assign ofs_eff = dbl ? 3'd0 : (in_ofs > 3'(MAX_IN_OFS)) ? 3'(MAX_IN_OFS) : in_ofs;

    tfs_edge_sync u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .sclk   (sclk),
        .fsync  (fsync),
        .rise_ev(rise_ev),
        .fall_ev(fall_ev),
        .fp_lvl (fp_lvl)
    );

    tfs_pol_detect #(.WINW(WINW)) u_pol (
        .clk    (clk),
        .rst_n  (rst_n),
        .rise_ev(rise_ev),
        .fp_lvl (fp_lvl),
        .win_len(win_len),
        .locked (locked),
        .pol_neg(fmt_neg)
    );

    // boundary edge type follows the detected format
    assign a_ev     = fmt_neg ? fall_ev : rise_ev;
    assign b_ev     = fmt_neg ? rise_ev : fall_ev;
    assign a_adv    = a_ev && locked;
    assign fp_act   = fp_lvl ^ fmt_neg;
    assign tx_start = a_adv && fp_act && !fp_prev;

    assign in_restart = a_adv && ((tx_start && ofs_eff == 3'd0) || dly == 3'd1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fp_prev   <= 1'b0;
            dly       <= '0;
            frame_stb <= 1'b0;
            rx_stb    <= 1'b0;
        end else begin
            frame_stb <= tx_start;
            rx_stb    <= b_ev && locked && (!dbl || rx_ph);
            if (a_adv) begin
                fp_prev <= fp_act;
                if (tx_start)          dly <= ofs_eff;
                else if (dly != 3'd0)  dly <= dly - 3'd1;
            end
        end
    end

    tfs_slot_counter #(.CHW(CHW)) u_tx_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv    (a_adv),
        .restart(tx_start),
        .dbl    (dbl),
        .ch_last(ch_last),
        .ph     (tx_ph),
        .bit_idx(tx_bit),
        .ch_idx (tx_ch),
        .bnd_stb(tx_stb)
    );

    tfs_slot_counter #(.CHW(CHW)) u_rx_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv    (a_adv),
        .restart(in_restart),
        .dbl    (dbl),
        .ch_last(ch_last),
        .ph     (rx_ph),
        .bit_idx(rx_bit),
        .ch_idx (rx_ch),
        .bnd_stb()
    );

endmodule

// File: rtl/tfs_checker.sv
module tfs_checker #(
    parameter  int BASE_CH = 32,
    localparam int CHW     = $clog2(BASE_CH * 4)
) (
    input logic           clk,
    input logic           rst_n,
    input logic [1:0]     rate_sel,
    input logic           locked,
    input logic           fmt_neg,
    input logic           tx_stb,
    input logic [2:0]     tx_bit,
    input logic [CHW-1:0] tx_ch,
    input logic           frame_stb,
    input logic           rx_stb,
    input logic [CHW-1:0] rx_ch
);
    // R11
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_stb && rx_stb));

    // R11
    quiet_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !locked |-> (!tx_stb && !rx_stb && !frame_stb));

    // R11
    tx_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_stb |=> !tx_stb);

    // R3
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> (locked && $stable(fmt_neg)));

    // R4
    frame_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_stb |-> (tx_stb && tx_bit == 3'd0 && tx_ch == '0));

    // R6
    dbl_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_stb && rate_sel == 2'd0) |-> (rx_ch < CHW'(BASE_CH)));

endmodule

bind tdm_frame_timer tfs_checker #(.BASE_CH(BASE_CH)) u_tfs_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rate_sel (rate_sel),
    .locked   (locked),
    .fmt_neg  (fmt_neg),
    .tx_stb   (tx_stb),
    .tx_bit   (tx_bit),
    .tx_ch    (tx_ch),
    .frame_stb(frame_stb),
    .rx_stb   (rx_stb),
    .rx_ch    (rx_ch)
);

// File: tb/test_tdm_frame_timer.sv
module test_tdm_frame_timer;
    localparam int CLK_PERIOD = 10;
    localparam int CHW = 7;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           sclk = 1'b0;
    logic           fsync = 1'b0;
    logic [1:0]     rate_sel = 2'd0;
    logic [2:0]     in_ofs = 3'd0;
    logic           locked, fmt_neg, tx_stb, frame_stb, rx_stb;
    logic [2:0]     tx_bit, rx_bit;
    logic [CHW-1:0] tx_ch, rx_ch;

    int checks = 0;
    int fails  = 0;

    // backplane model state
    int  cfg_neg, cfg_dbl, cfg_fcl, cfg_ofs;
    int  h;
    bit  last_a;
    int  last_c;
    bit  gate, seen1, seen2;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tdm_frame_timer i_tdm_frame_timer (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .fsync(fsync),
        .rate_sel(rate_sel), .in_ofs(in_ofs),
        .locked(locked), .fmt_neg(fmt_neg),
        .tx_stb(tx_stb), .tx_bit(tx_bit), .tx_ch(tx_ch), .frame_stb(frame_stb),
        .rx_stb(rx_stb), .rx_bit(rx_bit), .rx_ch(rx_ch)
    );

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int exp_bit(int c);
        return cfg_dbl ? (c / 2) % 8 : c % 8;
    endfunction

    function automatic int exp_ch(int c);
        return cfg_dbl ? c / 16 : c / 8;
    endfunction

    task automatic sample(int k);
        int  cc;
        bit  exp_tx, exp_rx;
        if (k == 1) gate = locked;
        if (k != 2) begin
            check("R11 tx idle", int'(tx_stb), 0);
            check("R11 rx idle", int'(rx_stb), 0);
            check("R11 frame idle", int'(frame_stb), 0);
            return;
        end
        if (!gate) begin
            check("R11 tx unlocked", int'(tx_stb), 0);
            check("R11 rx unlocked", int'(rx_stb), 0);
            return;
        end
        if (frame_stb && seen1) seen2 = 1'b1;
        if (frame_stb) seen1 = 1'b1;
        if (seen1) begin
            check("R4 frame_stb", int'(frame_stb), int'(last_a && last_c == 0));
            exp_tx = last_a && (!cfg_dbl || (last_c % 2 == 0));
            check(cfg_dbl ? "R5 R6 tx_stb" : "R5 R7 tx_stb", int'(tx_stb), int'(exp_tx));
            if (tx_stb && exp_tx) begin
                check("R8 tx_bit", int'(tx_bit), exp_bit(last_c));
                check("R8 tx_ch", int'(tx_ch), exp_ch(last_c));
            end
        end
        if (seen2) begin
            exp_rx = !last_a && (!cfg_dbl || (last_c % 2 == 1));
            check(cfg_dbl ? "R5 R6 rx_stb" : "R5 R7 rx_stb", int'(rx_stb), int'(exp_rx));
            if (rx_stb && exp_rx) begin
                cc = cfg_dbl ? last_c : (last_c - cfg_ofs + cfg_fcl) % cfg_fcl;
                check(cfg_dbl ? "R10 rx_bit" : "R9 rx_bit", int'(rx_bit), exp_bit(cc));
                check(cfg_dbl ? "R10 rx_ch" : "R9 rx_ch", int'(rx_ch), exp_ch(cc));
            end
        end
    endtask

    // drive one clock edge (current time is a negedge of clk)
    task automatic step_edge();
        bit is_a, act;
        is_a = (h % 2 == 0);
        act  = (h == 2 * cfg_fcl - 1) || (h == 0);
        sclk  = (cfg_neg != 0) ? !is_a : is_a;
        fsync = (cfg_neg != 0) ? !act : act;
        last_a = is_a;
        last_c = h / 2;
        h = (h + 1) % (2 * cfg_fcl);
        for (int k = 1; k <= 3; k++) begin
            @(negedge clk);
            sample(k);
        end
    endtask

    task automatic run_scenario(int neg, int rate, int ofs);
        cfg_neg = neg;
        cfg_dbl = (rate == 0);
        cfg_fcl = (rate == 0) ? 512 : (rate == 1) ? 512 : 1024;
        cfg_ofs = cfg_dbl ? 0 : ((ofs > 4) ? 4 : ofs);
        rate_sel = 2'(rate);
        in_ofs   = 3'(ofs);
        h = 2 * cfg_fcl - 10;
        seen1 = 1'b0;
        seen2 = 1'b0;
        gate  = 1'b0;
        sclk  = (neg != 0) ? 1'b1 : 1'b0;
        fsync = (neg != 0) ? 1'b1 : 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 locked", int'(locked), 0);
        check("R1 fmt_neg", int'(fmt_neg), 0);
        check("R1 tx_stb", int'(tx_stb), 0);
        check("R1 rx_stb", int'(rx_stb), 0);
        check("R1 frame_stb", int'(frame_stb), 0);
        for (int s = 0; s < 4 * cfg_fcl - 4; s++) step_edge();
        check("R3 no early lock", int'(locked), 0);
        for (int s = 0; s < 4 * cfg_fcl + 4; s++) step_edge();
        check("R3 locked", int'(locked), 1);
        check("R2 format", int'(fmt_neg), neg);
    endtask

    task automatic scen_pos_double();
        run_scenario(0, 0, 0);
        check("R6 frames seen", int'(seen2), 1);
    endtask

    task automatic scen_neg_double_ofs_ignored();
        run_scenario(1, 0, 3);
        check("R10 frames seen", int'(seen2), 1);
    endtask

    task automatic scen_pos_eq64_ofs2();
        run_scenario(0, 1, 2);
        check("R9 frames seen", int'(seen2), 1);
    endtask

    task automatic scen_neg_eq128_ofs1();
        run_scenario(1, 2, 1);
        check("R7 frames seen", int'(seen2), 1);
    endtask

    task automatic scen_code3_ofs_clamp();
        run_scenario(0, 3, 7);
        check("R9 clamp frames seen", int'(seen2), 1);
    endtask

    initial begin
        scen_pos_double();
        scen_neg_double_ofs_ignored();
        scen_pos_eq64_ofs2();
        scen_neg_eq128_ofs1();
        scen_code3_ofs_clamp();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 190000);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule